// File: doc/BRIEF.md
# Addressable Output Latch Bank

This block is the digital core of an eight-channel low-side switch. A three-bit address picks one of eight state bits. Each bit stores whether its channel should conduct. Each bit is driven out as an output-on signal that gates a power driver outside the block.

A host writes a channel by pulling the active-low select low. While select stays low, the addressed bit follows the data line level by level, so the host can pulse-width modulate that one channel through data alone. When select goes high again, the bit keeps the last value it saw.

An active-low clear empties every bit. An enable input and an over-temperature flag each blank all outputs without touching the stored bits. Every input is a plain level pin, so the block has no valid/ready handshake and applies no back-pressure. Each input passes a two-flop synchronizer before use.

Top module: `addr_latch_bank`

## Requirements
- R1: The address word `sel_addr` selects channel number `sel_addr` (0 to 7). Bit 2 is the most significant bit and bit 0 the least significant. Only that channel's bit is written.
- R2: While `cs_n` is low and `clr_n` is high, the addressed bit copies `wr_data` on every clock. A data level of 1 means on and 0 means off, so toggling `wr_data` toggles that output.
- R3: While `cs_n` is high, no bit changes. When `cs_n` rises, the addressed bit keeps the data value from the last write cycle.
- R4: During a write, the bits of all channels that are not addressed keep their values.
- R5: While `clr_n` is low, all bits are forced to 0 whatever the level of `cs_n`. Clear wins over a write that happens at the same time.
- R6: While `oe` is low, `drive_on` is all zero and the stored bits are kept. While `oe` is high, and no other blanking input is active, each `drive_on` bit equals its stored bit.
- R7: While `ovt` is high, `drive_on` is all zero. The stored bits are kept, and writes still update them.
- R8: While `rst_n` is low, the stored bits and `drive_on` are all zero. They stay zero after release until a write occurs.
- R9: A write reaches `drive_on` on the third rising clock edge after the inputs change, and not earlier.
- R10: With the input levels a floating interface would present, `drive_on` is all zero. Those levels are address all ones, data 1, and `cs_n`, `oe` and `clr_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_addr | input | 3 | Channel address, bit 2 most significant |
| wr_data | input | 1 | Level written to the addressed channel |
| cs_n | input | 1 | Active-low select; low makes the addressed bit follow `wr_data` |
| clr_n | input | 1 | Active-low clear of all stored bits |
| oe | input | 1 | Output enable; low blanks all outputs |
| ovt | input | 1 | Over-temperature flag; high blanks all outputs |
| drive_on | output | 8 | Per-channel on command |

## Verification
The assertions check several properties on every cycle, working on the synchronized inputs:
- clear empties the bank;
- a deselected bank holds its state;
- a write lands only in the addressed bit;
- enable and over-temperature blank the outputs;
- the outputs equal the stored bits when nothing blanks them.

Other behaviour shows only in the bench's scenarios, measured at the pins:
- the three-edge latency;
- that the last value is retained when select rises together with a data change;
- that stored bits survive blanking;
- every one of the 256 output patterns written through all eight addresses.

// File: rtl/olb_pkg.sv
package olb_pkg;
  // Synchronized control levels used by the bank
  typedef struct packed {
    logic data;
    logic cs_n;
    logic clr_n;
    logic oe;
    logic ovt;
  } olb_ctl_t;

  localparam int CTL_W = $bits(olb_ctl_t);
  // Safe levels while in reset: no write, clear active, blanked
  localparam olb_ctl_t CTL_RST = '{data: 1'b0, cs_n: 1'b1, clr_n: 1'b0, oe: 1'b0, ovt: 1'b0};
endpackage

// File: rtl/olb_sync.sv
module olb_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= RST_VAL;
      else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/olb_latch_bank.sv
module olb_latch_bank #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              data,
  input  logic              cs_n,
  input  logic              clr_n,
  output logic [NUM_CH-1:0] q
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    assign hit = (addr == ADDR_W'(ch));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q[ch] <= 1'b0;
      else if (!clr_n)       q[ch] <= 1'b0;
      else if (!cs_n && hit) q[ch] <= data;
    end
  end
endmodule

// File: rtl/olb_out_gate.sv
module olb_out_gate #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] q,
  input  logic              oe,
  input  logic              clr_n,
  input  logic              ovt,
  output logic [NUM_CH-1:0] on
);
  logic en;
  assign en = oe & clr_n & ~ovt;
  assign on = q & {NUM_CH{en}};
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank #(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic              wr_data,
  input  logic              cs_n,
  input  logic              clr_n,
  input  logic              oe,
  input  logic              ovt,
  output logic [NUM_CH-1:0] drive_on
);
  import olb_pkg::*;

  localparam int IN_W = ADDR_W + CTL_W;
  localparam logic [IN_W-1:0] IN_RST = {ADDR_W'(0), CTL_RST};

  logic [IN_W-1:0]   raw_in;
  logic [IN_W-1:0]   syn_in;
  logic [ADDR_W-1:0] s_addr;
  olb_ctl_t          s_ctl;
  logic [NUM_CH-1:0] latch_q;

  assign raw_in = {sel_addr, wr_data, cs_n, clr_n, oe, ovt};

  olb_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign s_addr = syn_in[IN_W-1 -: ADDR_W];
  assign s_ctl  = olb_ctl_t'(syn_in[CTL_W-1:0]);

  olb_latch_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .addr(s_addr), .data(s_ctl.data),
    .cs_n(s_ctl.cs_n), .clr_n(s_ctl.clr_n), .q(latch_q)
  );

  olb_out_gate #(.NUM_CH(NUM_CH)) u_gate (
    .q(latch_q), .oe(s_ctl.oe), .clr_n(s_ctl.clr_n), .ovt(s_ctl.ovt), .on(drive_on)
  );
endmodule

// File: rtl/addr_latch_bank_chk.sv
module addr_latch_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] s_addr,
  input logic              s_data,
  input logic              s_cs_n,
  input logic              s_clr_n,
  input logic              s_oe,
  input logic              s_ovt,
  input logic [NUM_CH-1:0] latch_q,
  input logic [NUM_CH-1:0] drive_on
);
  logic [NUM_CH-1:0] hit_mask;
  assign hit_mask = NUM_CH'(1) << s_addr;

  assert_reset_empty_R8: assert property (@(posedge clk)
    !rst_n |=> latch_q == '0);

  assert_clear_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !s_clr_n |=> latch_q == '0);

  assert_hold_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs_n && s_clr_n) |=> $stable(latch_q));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_cs_n && s_clr_n) |=> latch_q[$past(s_addr)] == $past(s_data));

  assert_others_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_cs_n && s_clr_n) |=> ((latch_q ^ $past(latch_q)) & ~$past(hit_mask)) == '0);

  assert_oe_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !s_oe |-> drive_on == '0);

  assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_oe && s_clr_n && !s_ovt) |-> drive_on == latch_q);

  assert_ovt_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ovt |-> drive_on == '0);
endmodule

bind addr_latch_bank addr_latch_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_data(s_ctl.data),
  .s_cs_n(s_ctl.cs_n), .s_clr_n(s_ctl.clr_n), .s_oe(s_ctl.oe), .s_ovt(s_ctl.ovt),
  .latch_q(latch_q), .drive_on(drive_on)
);

// File: tb/addr_latch_bank_bench.sv
module addr_latch_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel_addr;
  logic       wr_data, cs_n, clr_n, oe, ovt;
  logic [7:0] drive_on;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  addr_latch_bank u_addr_latch_bank (
    .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .wr_data(wr_data),
    .cs_n(cs_n), .clr_n(clr_n), .oe(oe), .ovt(ovt), .drive_on(drive_on)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (drive_on !== exp) begin
      errors++;
      $display("FAIL %s: drive_on=%02h expected=%02h", req, drive_on, exp);
    end
  endtask

  // One write cycle per channel, C-B-A order 0..7, then select released
  task automatic write_pattern(input logic [7:0] p);
    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sel_addr = 3'(i);
      wr_data  = p[i];
      wait_cyc(1);
    end
    cs_n = 1'b1;
    wait_cyc(3);
  endtask

  task automatic pulse_clear;
    clr_n = 1'b0;
    wait_cyc(3);
    clr_n = 1'b1;
    wait_cyc(3);
  endtask

  initial begin
    rst_n = 1'b0; sel_addr = 3'd7; wr_data = 1'b1;
    cs_n = 1'b0; oe = 1'b0; clr_n = 1'b0; ovt = 1'b0;
    wait_cyc(2);
    chk("R8 in reset", 8'h00);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R10 floating levels", 8'h00);

    // Release clear only; a write to channel 7 happens but oe blanks it
    clr_n = 1'b1;
    wait_cyc(4);
    chk("R6 blanked write", 8'h00);
    oe = 1'b1; cs_n = 1'b1;
    wait_cyc(3);
    chk("R6 kept bit shows", 8'h80);

    // R1: single-channel decode, bit 2 is MSB
    for (int a = 0; a < 8; a++) begin
      pulse_clear();
      cs_n = 1'b0; sel_addr = 3'(a); wr_data = 1'b1;
      wait_cyc(1);
      cs_n = 1'b1;
      wait_cyc(3);
      chk("R1 decode", 8'(1 << a));
    end

    // R4/R1: exhaustive patterns through all addresses
    for (int p = 0; p < 256; p++) begin
      write_pattern(8'(p));
      chk("R4 pattern", 8'(p));
    end

    // R9 latency then R2 modulation on channel 2
    pulse_clear();
    cs_n = 1'b0; sel_addr = 3'd2; wr_data = 1'b1;
    wait_cyc(2);
    chk("R9 not before third edge", 8'h00);
    wait_cyc(1);
    chk("R9 at third edge", 8'h04);
    wr_data = 1'b0; wait_cyc(3);
    chk("R2 follow low", 8'h00);
    wr_data = 1'b1; wait_cyc(3);
    chk("R2 follow high", 8'h04);

    // R3: select rises with data change; last value kept
    cs_n = 1'b1; wr_data = 1'b0;
    wait_cyc(3);
    chk("R3 last value kept", 8'h04);
    sel_addr = 3'd6; wr_data = 1'b1;
    wait_cyc(4);
    chk("R3 deselected ignore", 8'h04);

    // R5: clear wins over simultaneous write
    cs_n = 1'b0; clr_n = 1'b0;
    wait_cyc(3);
    chk("R5 clear during write", 8'h00);
    cs_n = 1'b1; clr_n = 1'b1;
    wait_cyc(3);
    chk("R5 bank emptied", 8'h00);

    // R6: enable blanking preserves contents
    write_pattern(8'hA5);
    oe = 1'b0; wait_cyc(3);
    chk("R6 oe low", 8'h00);
    oe = 1'b1; wait_cyc(3);
    chk("R6 oe restored", 8'hA5);

    // R7: over-temperature blanking, write still lands
    ovt = 1'b1; wait_cyc(3);
    chk("R7 ovt blank", 8'h00);
    cs_n = 1'b0; sel_addr = 3'd1; wr_data = 1'b1;
    wait_cyc(1);
    cs_n = 1'b1; wait_cyc(3);
    chk("R7 write while hot", 8'h00);
    ovt = 1'b0; wait_cyc(3);
    chk("R7 recovered", 8'hA7);

    // R8: reset mid-run
    rst_n = 1'b0; wait_cyc(1);
    chk("R8 async reset", 8'h00);
    rst_n = 1'b1; wait_cyc(4);
    chk("R8 after release", 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule